// File: doc/BRIEF.md
# Multiplexor Subchannel Service Sequencer

This block arbitrates data service requests from a set of I/O channels and services one at a time. Among the requests pending when it is idle, the lowest-numbered channel wins. It holds that grant until the service completes. When the winner is the multiplexor channel, the block reads the selected device's subchannel word from an internal parity-protected store. It presents that word during a single byte-transfer handshake and then stores the updated word back, unless the device is running in burst mode. A request from any other channel gets the handshake alone, with no store access.

A parity fault found while reading a subchannel word cancels that service. The block completes it with the channel control check flag. It also marks the device, so that the next service for that device carries an end condition to the device electronics. Each service ends with a one-cycle done pulse, which lets the processor resume.

Top module: `mpxseq_svc`

## Requirements
- R1: When idle, the block grants the requesting channel with the lowest index (channel 0 has the highest priority). The grant vector is one-hot or zero.
- R2: The grant stays unchanged from the cycle after the winning request is sampled through the done cycle, and it drops in the following cycle. Requests that arrive while a service is in progress do not change it.
- R3: `xfer_req` rises one cycle after the grant for a channel other than the multiplexor channel (parameter MPX_CH, default 1), and two cycles after the grant for the multiplexor channel. It stays high until `xfer_ack` is sampled.
- R4: During a multiplexor transfer, `sc_word` shows the stored subchannel word of the device captured from `dev_addr` at grant. For any other channel, `sc_word` is zero and `xfer_end` is low.
- R5: In a multiplexor transfer that is not in burst mode, `upd_word`/`upd_par` are written back to the device's entry, and `svc_done` comes two cycles after the `xfer_ack` edge.
- R6: In a burst-mode multiplexor transfer or any non-multiplexor transfer, nothing is written back. `svc_done` comes one cycle after the `xfer_ack` edge, and the stored entry keeps its old value.
- R7: Each byte of the stored word is covered by one even-parity bit in `upd_par`: bit k pairs with bits 8k+7..8k, and the nine bits must hold an even number of ones. If the fetched entry fails this check, no transfer happens, `svc_done` follows the fetch, `chk_ctl` is high with it, and the entry is left as it was.
- R8: After a parity fault, the next multiplexor service of that device skips the parity check. It raises `xfer_end` during its transfer, and completing that transfer clears the mark.
- R9: After reset, the grant, `xfer_req`, `svc_done` and `chk_ctl` are low, and every entry reads as zero with valid parity.
- R10: `svc_done` is a single-cycle pulse, and `chk_ctl` is high only together with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| svc_req | input | NCH | Data service request per channel |
| dev_addr | input | log2(DEPTH) | Device on the multiplexor channel, sampled at grant |
| svc_gnt | output | NCH | One-hot grant, held for the whole service |
| xfer_req | output | 1 | Byte-transfer handshake request |
| xfer_end | output | 1 | End condition to the device during the transfer |
| sc_word | output | WORD | Fetched subchannel word during a multiplexor transfer |
| xfer_ack | input | 1 | Transfer complete |
| upd_word | input | WORD | Updated subchannel word, sampled with `xfer_ack` |
| upd_par | input | WORD/8 | Byte parity of `upd_word`, stored as given |
| burst_mode | input | 1 | Burst flag, sampled with `xfer_ack` |
| svc_done | output | 1 | One-cycle completion pulse |
| chk_ctl | output | 1 | Channel control check, with `svc_done` |

## Verification
A sequencer stuck in a wrong state shows at once in the spacing between grant, `xfer_req` and `svc_done`. The bench counts those gaps to the cycle, so a skipped fetch or a spurious writeback changes them by one. A wrong writeback decision leaves the grant timing intact but corrupts the store, which shows up only at the next fetch of the same device, in `sc_word`. A lost or stray fault mark shows up at the next service of the affected device, either as a missing `xfer_end` or as a second check.

// File: rtl/mpxseq_pkg.sv
package mpxseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_GRANT,
    S_FETCH,
    S_XFER,
    S_WB,
    S_RET
  } seq_state_e;
endpackage

// File: rtl/mpxseq_prio.sv
// Fixed-priority pick: the lowest set request bit wins.
module mpxseq_prio #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] pick,
  output logic           any
);
  assign pick = req & (~req + NCH'(1));
  assign any  = |req;
endmodule

// File: rtl/mpxseq_scstore.sv
// Subchannel store: one word plus byte parity per device, one-cycle read.
module mpxseq_scstore #(
  parameter  int DEPTH = 16,
  parameter  int WORD  = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int NB    = WORD / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [WORD-1:0] rd_word,
  output logic            rd_bad,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [WORD-1:0] wr_word,
  input  logic [NB-1:0]   wr_par
);
  logic [WORD-1:0] mem_w [DEPTH];
  logic [NB-1:0]   mem_p [DEPTH];
  logic [NB-1:0]   rd_par;
  logic [NB-1:0]   byte_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_w[i] <= '0;
        mem_p[i] <= '0;
      end
    end else if (wr_en) begin
      mem_w[wr_addr] <= wr_word;
      mem_p[wr_addr] <= wr_par;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word <= '0;
      rd_par  <= '0;
    end else if (rd_en) begin
      rd_word <= mem_w[rd_addr];
      rd_par  <= mem_p[rd_addr];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_par
    assign byte_bad[b] = ^{rd_word[8*b +: 8], rd_par[b]};
  end
  assign rd_bad = |byte_bad;
endmodule

// File: rtl/mpxseq_svc.sv
module mpxseq_svc
  import mpxseq_pkg::*;
#(
  parameter  int NCH    = 4,
  parameter  int MPX_CH = 1,
  parameter  int DEPTH  = 16,
  parameter  int WORD   = 32,
  localparam int AW     = $clog2(DEPTH),
  localparam int NB     = WORD / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  svc_req,
  input  logic [AW-1:0]   dev_addr,
  output logic [NCH-1:0]  svc_gnt,
  output logic            xfer_req,
  output logic            xfer_end,
  output logic [WORD-1:0] sc_word,
  input  logic            xfer_ack,
  input  logic [WORD-1:0] upd_word,
  input  logic [NB-1:0]   upd_par,
  input  logic            burst_mode,
  output logic            svc_done,
  output logic            chk_ctl
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  seq_state_e      state_q, state_d;
  logic [NCH-1:0]  pick, gnt_q;
  logic            any_req, is_mpx;
  logic [AW-1:0]   dev_q;
  logic [WORD-1:0] fetch_word, upd_q;
  logic [NB-1:0]   updp_q;
  logic            fetch_bad, ccc_q;
  logic [DEPTH-1:0] endp_q;
  logic            end_mark, par_fault;
  logic            gnt_load, gnt_clr, rd_en, wr_en, set_end, clr_end, ack_take;

  mpxseq_prio #(.NCH(NCH)) u_prio (
    .req  (svc_req),
    .pick (pick),
    .any  (any_req)
  );

  mpxseq_scstore #(.DEPTH(DEPTH), .WORD(WORD)) u_store (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .rd_en   (rd_en),
    .rd_addr (dev_q),
    .rd_word (fetch_word),
    .rd_bad  (fetch_bad),
    .wr_en   (wr_en),
    .wr_addr (dev_q),
    .wr_word (upd_q),
    .wr_par  (updp_q)
  );

  assign is_mpx    = gnt_q[MPX_CH];
  assign end_mark  = endp_q[dev_q];
  assign par_fault = (state_q == S_FETCH) && fetch_bad && !end_mark;

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (any_req) state_d = S_GRANT;
      S_GRANT: state_d = is_mpx ? S_FETCH : S_XFER;
      S_FETCH: state_d = par_fault ? S_RET : S_XFER;
      S_XFER:  if (xfer_ack) state_d = (is_mpx && !burst_mode) ? S_WB : S_RET;
      S_WB:    state_d = S_RET;
      S_RET:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // enables
  assign gnt_load = (state_q == S_IDLE) && any_req;
  assign gnt_clr  = (state_q == S_RET);
  assign rd_en    = (state_q == S_GRANT) && is_mpx;
  assign ack_take = (state_q == S_XFER) && xfer_ack;
  assign wr_en    = (state_q == S_WB);
  assign set_end  = par_fault;
  assign clr_end  = ack_take && is_mpx;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) state_q <= S_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)      gnt_q <= '0;
    else if (gnt_load) gnt_q <= pick;
    else if (gnt_clr)  gnt_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)      dev_q <= '0;
    else if (gnt_load) dev_q <= dev_addr;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      upd_q  <= '0;
      updp_q <= '0;
    end else if (ack_take) begin
      upd_q  <= upd_word;
      updp_q <= upd_par;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)      ccc_q <= 1'b0;
    else if (gnt_load) ccc_q <= 1'b0;
    else if (set_end)  ccc_q <= 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_endp
    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n)                          endp_q[g] <= 1'b0;
      else if (set_end && dev_q == AW'(g))   endp_q[g] <= 1'b1;
      else if (clr_end && dev_q == AW'(g))   endp_q[g] <= 1'b0;
    end
  end

  assign svc_gnt  = gnt_q;
  assign xfer_req = (state_q == S_XFER);
  assign xfer_end = xfer_req && is_mpx && end_mark;
  assign sc_word  = (xfer_req && is_mpx) ? fetch_word : '0;
  assign svc_done = (state_q == S_RET);
  assign chk_ctl  = svc_done && ccc_q;
endmodule

// File: rtl/mpxseq_svc_chk.sv
module mpxseq_svc_chk #(
  parameter int NCH    = 4,
  parameter int MPX_CH = 1,
  parameter int WORD   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  svc_req,
  input logic [NCH-1:0]  svc_gnt,
  input logic            xfer_req,
  input logic            xfer_end,
  input logic [WORD-1:0] sc_word,
  input logic            svc_done,
  input logic            chk_ctl
);
  logic [NCH-1:0] below;
  assign below = svc_gnt - NCH'(1);

  assert_gnt_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_gnt));

  assert_gnt_priority_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(svc_gnt) == '0 && svc_gnt != '0) |->
      ((svc_gnt & $past(svc_req)) != '0 && (below & $past(svc_req)) == '0));

  assert_gnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_gnt != '0 && !svc_done) |=> $stable(svc_gnt));

  assert_gnt_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    svc_done |=> (svc_gnt == '0));

  assert_xfer_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (svc_gnt != '0));

  assert_quiet_other_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !svc_gnt[MPX_CH]) |-> (sc_word == '0 && !xfer_end));

  assert_check_mpx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ctl |-> (svc_gnt[MPX_CH] && !xfer_req));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    svc_done |=> !svc_done);

  assert_check_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ctl |-> svc_done);
endmodule

bind mpxseq_svc mpxseq_svc_chk #(.NCH(NCH), .MPX_CH(MPX_CH), .WORD(WORD)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .svc_req  (svc_req),
  .svc_gnt  (svc_gnt),
  .xfer_req (xfer_req),
  .xfer_end (xfer_end),
  .sc_word  (sc_word),
  .svc_done (svc_done),
  .chk_ctl  (chk_ctl)
);

// File: tb/sim_mpxseq_svc.sv
`timescale 1ns/1ps
module sim_mpxseq_svc;
  localparam int NCH = 4, MPX = 1, DEPTH = 16, WORD = 32, AW = 4, NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]  svc_req = '0;
  logic [AW-1:0]   dev_addr = '0;
  logic [NCH-1:0]  svc_gnt;
  logic            xfer_req, xfer_end, xfer_ack = 1'b0;
  logic [WORD-1:0] sc_word, upd_word = '0;
  logic [NB-1:0]   upd_par = '0;
  logic            burst_mode = 1'b0;
  logic            svc_done, chk_ctl;

  int compared = 0, mismatched = 0;

  typedef struct { bit ccc; int win; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  mpxseq_svc #(.NCH(NCH), .MPX_CH(MPX), .DEPTH(DEPTH), .WORD(WORD)) u0 (
    .clk(clk), .rst_n(rst_n), .svc_req(svc_req), .dev_addr(dev_addr),
    .svc_gnt(svc_gnt), .xfer_req(xfer_req), .xfer_end(xfer_end),
    .sc_word(sc_word), .xfer_ack(xfer_ack), .upd_word(upd_word),
    .upd_par(upd_par), .burst_mode(burst_mode), .svc_done(svc_done),
    .chk_ctl(chk_ctl)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] gpar(input logic [WORD-1:0] w);
    logic [NB-1:0] p;
    for (int b = 0; b < NB; b++) p[b] = ^w[8*b +: 8];
    return p;
  endfunction

  // monitor: pops expected completions as done pulses appear
  always @(negedge clk) begin
    if (rst_n && svc_done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected done", 32'(svc_done), 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(chk_ctl == e.ccc, "R7/R10 check flag at done", 32'(chk_ctl), 32'(e.ccc));
        chk(svc_gnt == NCH'(1 << e.win), "R2 grant held at done", 32'(svc_gnt), 32'(1 << e.win));
      end
    end
  end

  // driver: one service from request to completion
  task automatic serve(input logic [NCH-1:0] reqv, input logic [AW-1:0] dev, input int win,
                       input bit burst, input logic [WORD-1:0] upd, input logic [NB-1:0] upar,
                       input bit exp_ccc, input logic [WORD-1:0] exp_word, input bit exp_end,
                       input bit intrude);
    bit saw_x;
    int lat, wait_n, exp_lat;
    logic [NCH-1:0] g0;
    exp_q.push_back('{exp_ccc, win});
    svc_req  = reqv;
    dev_addr = dev;
    wait_n = 0;
    do begin @(negedge clk); wait_n++; end while (svc_gnt == '0 && wait_n < 20);
    chk(svc_gnt == NCH'(1 << win), "R1 priority winner", 32'(svc_gnt), 32'(1 << win));
    g0 = svc_gnt;
    svc_req  = intrude ? NCH'(1) : '0;
    dev_addr = dev + AW'(1);
    saw_x = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk(svc_gnt == g0, "R2 grant stable", 32'(svc_gnt), 32'(g0));
      if (xfer_req) begin
        saw_x = 1'b1;
        chk(i == ((win == MPX) ? 1 : 0), "R3 transfer start delay", 32'(i), 32'((win == MPX) ? 1 : 0));
        chk(sc_word == exp_word, "R4 subchannel word", sc_word, exp_word);
        chk(xfer_end == exp_end, "R8 end condition", 32'(xfer_end), 32'(exp_end));
        xfer_ack = 1'b1; upd_word = upd; upd_par = upar; burst_mode = burst;
        @(negedge clk);
        xfer_ack = 1'b0;
        lat = 1;
        while (!svc_done && lat < 6) begin @(negedge clk); lat++; end
        exp_lat = (win == MPX && !burst) ? 2 : 1;
        chk(lat == exp_lat, (exp_lat == 2) ? "R5 writeback latency" : "R6 direct return latency",
            32'(lat), 32'(exp_lat));
        break;
      end else if (svc_done) begin
        break;
      end
    end
    chk(saw_x == !exp_ccc, "R7 transfer skipped on fault", 32'(saw_x), 32'(!exp_ccc));
    @(negedge clk);
    chk(!svc_done && svc_gnt == '0, "R10 done single cycle, R2 grant dropped",
        32'({svc_done, svc_gnt}), 32'h0);
  endtask

  initial begin
    #(5.0 * 100000);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [WORD-1:0] wa, wb, wc, wd, we;
    wa = 32'h1234_5678; wb = 32'hCAFE_0001; wc = 32'h0F0F_A5A5;
    wd = 32'hDEAD_BEEF; we = 32'h0000_8001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(svc_gnt == '0 && !xfer_req && !svc_done && !chk_ctl, "R9 reset outputs",
        32'({svc_gnt, xfer_req, svc_done, chk_ctl}), 32'h0);
    // R9/R4/R5: first fetch reads zero; non-burst writes back
    serve(4'b0010, 4'd3, 1, 1'b0, wa, gpar(wa), 1'b0, 32'h0, 1'b0, 1'b0);
    serve(4'b0010, 4'd3, 1, 1'b1, wb, gpar(wb), 1'b0, wa, 1'b0, 1'b0);
    // R6: burst left entry at wa
    serve(4'b0010, 4'd3, 1, 1'b0, wc, gpar(wc), 1'b0, wa, 1'b0, 1'b0);
    serve(4'b0010, 4'd3, 1, 1'b1, wc, gpar(wc), 1'b0, wc, 1'b0, 1'b0);
    // R9: other device untouched
    serve(4'b0010, 4'd7, 1, 1'b1, wd, gpar(wd), 1'b0, 32'h0, 1'b0, 1'b0);
    // R1/R4/R6: priority patterns, non-multiplexor channels never write back
    serve(4'b1100, 4'd3, 2, 1'b0, wd, gpar(wd), 1'b0, 32'h0, 1'b0, 1'b0);
    serve(4'b0111, 4'd3, 0, 1'b0, wd, gpar(wd), 1'b0, 32'h0, 1'b0, 1'b0);
    serve(4'b1010, 4'd3, 1, 1'b1, wd, gpar(wd), 1'b0, wc, 1'b0, 1'b0);
    serve(4'b1000, 4'd3, 3, 1'b0, wd, gpar(wd), 1'b0, 32'h0, 1'b0, 1'b0);
    // R2: higher-priority request during a service waits
    serve(4'b0010, 4'd3, 1, 1'b1, wd, gpar(wd), 1'b0, wc, 1'b0, 1'b1);
    serve(4'b0001, 4'd3, 0, 1'b0, wd, gpar(wd), 1'b0, 32'h0, 1'b0, 1'b0);
    // R7/R8: bad parity stored, fault, end condition, repair
    serve(4'b0010, 4'd5, 1, 1'b0, wd, gpar(wd) ^ 4'b0100, 1'b0, 32'h0, 1'b0, 1'b0);
    serve(4'b0010, 4'd5, 1, 1'b0, we, gpar(we), 1'b1, 32'h0, 1'b0, 1'b0);
    serve(4'b0010, 4'd5, 1, 1'b0, we, gpar(we), 1'b0, wd, 1'b1, 1'b0);
    serve(4'b0010, 4'd5, 1, 1'b1, wa, gpar(wa), 1'b0, we, 1'b0, 1'b0);
    // R8: mark is per device
    serve(4'b0010, 4'd3, 1, 1'b1, wa, gpar(wa), 1'b0, wc, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all completions seen", 32'(exp_q.size()), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule